// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a 32-bit processor core that runs in one of eight operating modes. At any time sixteen general registers (index 0 to 15) are addressable, together with the current status word. In the six exception modes a saved status word can also be reached. The core presents the current mode code on `mode_i`. The block turns every register index into a physical storage slot. Each exception mode therefore works on its own stack pointer (index 13) and link register (index 14), and the fast-interrupt mode also has private copies of indices 8 to 12.

There are two combinational read ports and one general write port. A separate link port loads index 14 of the current mode when a branch-with-link is signalled. The status side has write strobes for the current and saved status words. It also has an exception-entry strobe, which copies the current status word into the saved status slot of the mode being entered. Instruction decode, exception arbitration and program-counter stepping are done elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_ni` is low and after it is released, every register in every mode reads zero, and so do the current and saved status words.
- R2: `ra_data_o` and `rb_data_o` show, in the same cycle, the register chosen by `ra_idx_i` / `rb_idx_i` for the mode on `mode_i`. Indices 0 to 7 map to the same storage in all modes.
- R3: A write with `wr_en_i` high lands on the rising clock edge, in the slot selected by the `mode_i` of that cycle, and can be read from the next cycle on. `cpsr_we_i` updates the current status word the same way.
- R4: User (10000) and System (11111) share every register, including indices 13 and 14. Any mode code not listed in R11 behaves as User.
- R5: Each exception mode has private copies of indices 13 and 14, so writes to them are not seen from any other mode. Index 15 is shared by all modes.
- R6: FIQ mode has private copies of indices 8 to 12. All other modes share one copy of indices 8 to 12.
- R7: Index 15 is the program counter. Its bits 1:0 always read zero, and writes drop them.
- R8: `link_en_i` loads `link_addr_i` into index 14 of the current mode. If the general write port targets the same register in the same cycle, the link value is the one kept.
- R9: In User, System or an unlisted mode, `spsr_o` reads zero and `spsr_we_i` changes no saved status word.
- R10: `exc_en_i` copies the current status word, as it was before the edge, into the saved status slot of the exception mode given on `exc_mode_i`. This copy wins over `spsr_we_i` aimed at the same slot. If `exc_mode_i` is not an exception mode, nothing is saved.
- R11: Mode codes are FIQ 10001, IRQ 10010, Supervisor 10011, Monitor 10110, Abort 10111 and Undefined 11011, along with User and System from R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode code |
| ra_idx_i | input | 4 | Read port A register index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B register index |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write register index |
| wr_data_i | input | 32 | General write data |
| link_en_i | input | 1 | Branch-with-link: load index 14 |
| link_addr_i | input | 32 | Return address for index 14 |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of current mode |
| exc_en_i | input | 1 | Exception entry: save current status |
| exc_mode_i | input | 5 | Mode being entered on exception |

## Verification
A wrong slot mapping does not show up on the cycle of the faulty write. It appears only later, when the same index is read from another mode: either a value leaks across banks or an expected value is missing. For this reason the stimulus switches modes on almost every cycle. The reference model compares both read ports and both status outputs before every edge, so a fault is caught at the first read that crosses a bank. Faults in collision priority or in the saved-status capture appear one cycle after the colliding edge, as soon as the affected slot is read in its own mode.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int XLEN      = 32;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int NGPR      = 33;
  localparam int SLOT_W    = $clog2(NGPR);
  localparam int NBANK     = 7;
  localparam int BANK_W    = $clog2(NBANK);
  localparam int PC_IDX    = 15;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int FIQ_LO    = 8;
  localparam int FIQ_BASE  = 16;
  localparam int PRIV_BASE = 23;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [BANK_W-1:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
    BK_ABT = 3'd4, BK_UND = 3'd5, BK_MON = 3'd6
  } bank_e;

  // first private slot of the 13/14 pair for non-FIQ exception banks
  function automatic int pair_base(bank_e b);
    case (b)
      BK_IRQ:  return PRIV_BASE;
      BK_SVC:  return PRIV_BASE + 2;
      BK_ABT:  return PRIV_BASE + 4;
      BK_UND:  return PRIV_BASE + 6;
      BK_MON:  return PRIV_BASE + 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              is_exc_o
);
  always_comb begin
    case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      MODE_MON: bank_o = BK_MON;
      default:  bank_o = BK_USR;  // user, system, unlisted
    endcase
    is_exc_o = (bank_o != BK_USR);
  end
endmodule

// File: rtl/brf_slot_map.sv
module brf_slot_map
  import brf_pkg::*;
(
  input  bank_e              bank_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [SLOT_W-1:0]  slot_o
);
  always_comb begin
    slot_o = SLOT_W'(idx_i);
    if (int'(idx_i) != PC_IDX) begin
      if (bank_i == BK_FIQ && int'(idx_i) >= FIQ_LO)
        slot_o = SLOT_W'(FIQ_BASE + int'(idx_i) - FIQ_LO);
      else if (bank_i != BK_USR && bank_i != BK_FIQ && int'(idx_i) >= SP_IDX)
        slot_o = SLOT_W'(pair_base(bank_i) + int'(idx_i) - SP_IDX);
    end
  end
endmodule

// File: rtl/brf_gpr_bank.sv
module brf_gpr_bank
  import brf_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NGPR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_a_i,
  input  logic [SLOT_W-1:0] slot_a_i,
  input  logic [W-1:0]      data_a_i,
  input  logic              we_l_i,
  input  logic [SLOT_W-1:0] slot_l_i,
  input  logic [W-1:0]      data_l_i,
  input  logic [SLOT_W-1:0] rd_slot_a_i,
  input  logic [SLOT_W-1:0] rd_slot_b_i,
  output logic [W-1:0]      rd_data_a_o,
  output logic [W-1:0]      rd_data_b_o
);
  localparam logic [SLOT_W-1:0] PC_SLOT = SLOT_W'(PC_IDX);

  logic [W-1:0] mem_q [N];
  logic [W-1:0] wdata_a;

  assign wdata_a = (slot_a_i == PC_SLOT) ? {data_a_i[W-1:2], 2'b00} : data_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N; s++) mem_q[s] <= '0;
    end else begin
      for (int s = 0; s < N; s++) begin
        if (we_l_i && slot_l_i == SLOT_W'(s))      mem_q[s] <= data_l_i;  // link wins
        else if (we_a_i && slot_a_i == SLOT_W'(s)) mem_q[s] <= wdata_a;
      end
    end
  end

  assign rd_data_a_o = mem_q[rd_slot_a_i];
  assign rd_data_b_o = mem_q[rd_slot_b_i];

  // R3
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_i && !(we_l_i && slot_l_i == slot_a_i)) |=>
      mem_q[$past(slot_a_i)][W-1:2] == $past(data_a_i[W-1:2]));
  // R8
  link_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_l_i |=> mem_q[$past(slot_l_i)] == $past(data_l_i));
  // R7
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[PC_SLOT][1:0] == 2'b00);
endmodule

// File: rtl/brf_psr_bank.sv
module brf_psr_bank
  import brf_pkg::*;
#(
  parameter int W = XLEN,
  parameter int B = NBANK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  bank_e        cur_bank_i,
  input  logic         cur_exc_i,
  input  bank_e        exc_bank_i,
  input  logic         exc_valid_i,
  input  logic         cpsr_we_i,
  input  logic [W-1:0] cpsr_wdata_i,
  input  logic         spsr_we_i,
  input  logic [W-1:0] spsr_wdata_i,
  input  logic         exc_en_i,
  output logic [W-1:0] cpsr_o,
  output logic [W-1:0] spsr_o
);
  logic [W-1:0] cpsr_q;
  logic [W-1:0] spsr_q [B];  // entry 0 unused (normal bank)

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= '0;
      for (int b = 0; b < B; b++) spsr_q[b] <= '0;
    end else begin
      if (cpsr_we_i) cpsr_q <= cpsr_wdata_i;
      for (int b = 1; b < B; b++) begin
        if (exc_en_i && exc_valid_i && exc_bank_i == bank_e'(b))
          spsr_q[b] <= cpsr_q;
        else if (spsr_we_i && cur_exc_i && cur_bank_i == bank_e'(b))
          spsr_q[b] <= spsr_wdata_i;
      end
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = cur_exc_i ? spsr_q[cur_bank_i] : '0;

  // R10
  exc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && exc_valid_i) |=> spsr_q[$past(exc_bank_i)] == $past(cpsr_q));
  // R3
  cpsr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_q == $past(cpsr_wdata_i));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [W-1:0]      ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [W-1:0]      rb_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              link_en_i,
  input  logic [W-1:0]      link_addr_i,
  input  logic              cpsr_we_i,
  input  logic [W-1:0]      cpsr_wdata_i,
  output logic [W-1:0]      cpsr_o,
  input  logic              spsr_we_i,
  input  logic [W-1:0]      spsr_wdata_i,
  output logic [W-1:0]      spsr_o,
  input  logic              exc_en_i,
  input  logic [MODE_W-1:0] exc_mode_i
);
  localparam int NPORT = 4;  // ra, rb, wr, link

  bank_e cur_bank, exc_bank;
  logic  cur_exc, exc_valid;

  brf_mode_decode u_cur_dec (.mode_i(mode_i),     .bank_o(cur_bank), .is_exc_o(cur_exc));
  brf_mode_decode u_exc_dec (.mode_i(exc_mode_i), .bank_o(exc_bank), .is_exc_o(exc_valid));

  logic [IDX_W-1:0]  idx_v  [NPORT];
  logic [SLOT_W-1:0] slot_v [NPORT];

  assign idx_v[0] = ra_idx_i;
  assign idx_v[1] = rb_idx_i;
  assign idx_v[2] = wr_idx_i;
  assign idx_v[3] = IDX_W'(LR_IDX);

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    brf_slot_map u_map (.bank_i(cur_bank), .idx_i(idx_v[g]), .slot_o(slot_v[g]));
  end

  brf_gpr_bank #(.W(W), .N(NGPR)) u_gpr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_a_i      (wr_en_i),
    .slot_a_i    (slot_v[2]),
    .data_a_i    (wr_data_i),
    .we_l_i      (link_en_i),
    .slot_l_i    (slot_v[3]),
    .data_l_i    (link_addr_i),
    .rd_slot_a_i (slot_v[0]),
    .rd_slot_b_i (slot_v[1]),
    .rd_data_a_o (ra_data_o),
    .rd_data_b_o (rb_data_o)
  );

  brf_psr_bank #(.W(W), .B(NBANK)) u_psr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cur_bank_i   (cur_bank),
    .cur_exc_i    (cur_exc),
    .exc_bank_i   (exc_bank),
    .exc_valid_i  (exc_valid),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .spsr_we_i    (spsr_we_i),
    .spsr_wdata_i (spsr_wdata_i),
    .exc_en_i     (exc_en_i),
    .cpsr_o       (cpsr_o),
    .spsr_o       (spsr_o)
  );

  // R9
  spsr_normal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_USR || mode_i == MODE_SYS) |-> spsr_o == '0);
  // R5
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(slot_v[0]) < NGPR && int'(slot_v[1]) < NGPR && int'(slot_v[2]) < NGPR);
  // R7
  pc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ra_idx_i) == PC_IDX) |-> ra_data_o[1:0] == 2'b00);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 3000;

  logic        clk_i = 0, rst_ni = 0;
  logic [4:0]  mode_i = 5'b10000, exc_mode_i = 5'b10000;
  logic [3:0]  ra_idx_i = 0, rb_idx_i = 0, wr_idx_i = 0;
  logic [31:0] ra_data_o, rb_data_o, cpsr_o, spsr_o;
  logic        wr_en_i = 0, link_en_i = 0, cpsr_we_i = 0, spsr_we_i = 0, exc_en_i = 0;
  logic [31:0] wr_data_i = 0, link_addr_i = 0, cpsr_wdata_i = 0, spsr_wdata_i = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_gpr [33];
  logic [31:0] m_spsr [7];
  logic [31:0] m_cpsr;

  logic [4:0] modes [10] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10110,
                             5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10101};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  banked_regfile dut (.*);

  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      5'b10110: return 6;
      default:  return 0;
    endcase
  endfunction

  function automatic int slot_of(logic [4:0] m, int i);
    int b = bank_of(m);
    if (i == 15) return 15;
    if (b == 1 && i >= 8) return 8 + i;
    if (b >= 2 && i >= 13) return 23 + 2 * (b - 2) + (i - 13);
    return i;
  endfunction

  function automatic string tag_of(int i);
    if (i == 15) return "R7";
    if (i >= 13) return "R5";
    if (i >= 8)  return "R6";
    return "R2";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 33; s++) m_gpr[s] = '0;
    for (int b = 0; b < 7; b++) m_spsr[b] = '0;
    m_cpsr = '0;
  endtask

  // drive at negedge, compare combinational outputs, apply edge to model
  task automatic step(string tag);
    logic [31:0] old;
    int b;
    #1;
    chk(tag == "" ? tag_of(int'(ra_idx_i)) : tag, "ra", ra_data_o, m_gpr[slot_of(mode_i, int'(ra_idx_i))]);
    chk(tag == "" ? tag_of(int'(rb_idx_i)) : tag, "rb", rb_data_o, m_gpr[slot_of(mode_i, int'(rb_idx_i))]);
    chk(tag == "" ? "R3" : tag, "cpsr", cpsr_o, m_cpsr);
    b = bank_of(mode_i);
    chk(tag == "" ? (b == 0 ? "R9" : "R10") : tag, "spsr", spsr_o, b == 0 ? 32'h0 : m_spsr[b]);
    @(posedge clk_i);
    if (wr_en_i)
      m_gpr[slot_of(mode_i, int'(wr_idx_i))] = (wr_idx_i == 4'd15) ? {wr_data_i[31:2], 2'b00} : wr_data_i;
    if (link_en_i) m_gpr[slot_of(mode_i, 14)] = link_addr_i;
    old = m_cpsr;
    if (cpsr_we_i) m_cpsr = cpsr_wdata_i;
    if (spsr_we_i && b != 0) m_spsr[b] = spsr_wdata_i;
    if (exc_en_i && bank_of(exc_mode_i) != 0) m_spsr[bank_of(exc_mode_i)] = old;
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; link_en_i = 0; cpsr_we_i = 0; spsr_we_i = 0; exc_en_i = 0;
  endtask

  task automatic rd(logic [4:0] m, int a, int bb, string tag);
    idle(); mode_i = m; ra_idx_i = 4'(a); rb_idx_i = 4'(bb); step(tag);
  endtask

  task automatic wr(logic [4:0] m, int i, logic [31:0] d, string tag);
    idle(); mode_i = m; wr_en_i = 1; wr_idx_i = 4'(i); wr_data_i = d; step(tag);
  endtask

  initial begin
    void'($urandom(32'd1176));
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: outputs zero while reset held
    #1;
    chk("R1", "ra in reset", ra_data_o, 32'h0);
    chk("R1", "cpsr in reset", cpsr_o, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: all banks zero after reset
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 16; i += 2) rd(modes[k], i, i + 1, "R1");

    // R4: user/system/unlisted share R13, R14
    wr(5'b10000, 13, 32'hA5A5_0013, "R4");
    rd(5'b11111, 13, 14, "R4");
    rd(5'b00000, 13, 0, "R4");
    wr(5'b11111, 14, 32'h1111_2222, "R4");
    rd(5'b10000, 14, 13, "R4");
    // R5: exception modes see private R13/R14
    rd(5'b10011, 13, 14, "R5");
    wr(5'b10011, 13, 32'h5555_AAAA, "R5");
    rd(5'b10111, 13, 14, "R5");
    rd(5'b10011, 13, 13, "R5");
    rd(5'b10000, 13, 13, "R5");
    // R6: FIQ private R8-R12
    wr(5'b10001, 8, 32'hF1F1_0008, "R6");
    wr(5'b10000, 12, 32'h0C0C_0C0C, "R6");
    rd(5'b10001, 8, 12, "R6");
    rd(5'b10010, 8, 12, "R6");
    // R7: PC alignment
    wr(5'b10010, 15, 32'hFFFF_FFFF, "R7");
    rd(5'b10000, 15, 15, "R7");
    rd(5'b10110, 15, 0, "R7");
    // R8: link collision with general write to R14
    idle(); mode_i = 5'b11011; wr_en_i = 1; wr_idx_i = 4'd14; wr_data_i = 32'hDEAD_0001;
    link_en_i = 1; link_addr_i = 32'hBEEF_0004; step("R8");
    rd(5'b11011, 14, 13, "R8");
    rd(5'b10000, 14, 14, "R8");
    // R9: saved status write ignored in user/system
    idle(); mode_i = 5'b10000; spsr_we_i = 1; spsr_wdata_i = 32'h1234_5678; step("R9");
    idle(); mode_i = 5'b11111; spsr_we_i = 1; spsr_wdata_i = 32'h8765_4321; step("R9");
    for (int k = 1; k < 7; k++) rd(modes[k], 0, 1, "R9");
    // R10: exception save uses pre-edge cpsr and beats spsr write
    idle(); cpsr_we_i = 1; cpsr_wdata_i = 32'h0000_00D3; mode_i = 5'b10000; step("R10");
    idle(); mode_i = 5'b10111; cpsr_we_i = 1; cpsr_wdata_i = 32'h0000_0097;
    spsr_we_i = 1; spsr_wdata_i = 32'hCAFE_CAFE; exc_en_i = 1; exc_mode_i = 5'b10111; step("R10");
    rd(5'b10111, 0, 0, "R10");
    idle(); exc_en_i = 1; exc_mode_i = 5'b11111; mode_i = 5'b10011; step("R10");
    rd(5'b10011, 0, 0, "R10");
    // R11: each code reaches its own bank
    for (int k = 1; k < 7; k++) wr(modes[k], 13, 32'h0D00_0000 + 32'(k), "R11");
    for (int k = 0; k < 10; k++) rd(modes[k], 13, 14, "R11");

    // random traffic
    for (int n = 0; n < NSTEP; n++) begin
      mode_i       = modes[$urandom_range(9)];
      ra_idx_i     = 4'($urandom_range(15));
      rb_idx_i     = 4'($urandom_range(15));
      wr_en_i      = ($urandom_range(1) == 1);
      wr_idx_i     = 4'($urandom_range(15));
      wr_data_i    = $urandom;
      link_en_i    = ($urandom_range(7) == 0);
      link_addr_i  = $urandom;
      cpsr_we_i    = ($urandom_range(3) == 0);
      cpsr_wdata_i = $urandom;
      spsr_we_i    = ($urandom_range(3) == 0);
      spsr_wdata_i = $urandom;
      exc_en_i     = ($urandom_range(5) == 0);
      exc_mode_i   = modes[$urandom_range(9)];
      step("");
    end

    // R1: reset mid-run clears everything
    idle();
    rst_ni = 0; #1; rst_ni = 1;
    model_reset();
    @(negedge clk_i);
    for (int k = 0; k < 8; k++) rd(modes[k], 13, 8, "R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule